// File: doc/BRIEF.md
# Dual Reference Clock Switchover Controller

This block picks which of two reference clocks feeds a PLL phase detector: a primary reference and a backup reference. Both inputs are sampled in one fast system clock that runs at least four times faster than either reference. Each input is synchronized and turned into edge events, and every decision is made from those events.

In manual mode the choice comes from a select register bit or from a select pin. In automatic mode the block watches the primary for loss of activity, using the backup as the time base. On loss it moves to the backup. After the primary comes back, it either returns to the primary on its own (revert mode) or stays on the backup until software intervenes (hold mode). The selected reference leaves the block as a gated level. An optional handover guard keeps that level low after each change of selection until the new reference shows a clean rising edge.

Top module: `refclk_switch`

## Requirements
- R1: While reset is asserted, and right after it, `ref_gated`, `use_backup` and `pri_lost` are all 0.
- R2: `pri_lost` rises after two backup falling edges in a row pass with no primary edge of either polarity between them. A primary edge arriving between every pair of backup falling edges keeps it at 0. The monitor runs in both modes.
- R3: In automatic mode (`auto_mode`=1), once `pri_lost` is set, `use_backup` goes to 1 (1 = backup, 0 = primary) in the cycle after a detected backup rising edge, and not before one.
- R4: `pri_lost` clears only after four primary rising edges with fewer than two backup falling edges between each consecutive pair. A shorter run, or a run broken by two backup falling edges, leaves it set.
- R5: In automatic revert mode (`hold_backup`=0), when `pri_lost` is clear the selection returns to the primary.
- R6: In automatic hold mode (`hold_backup`=1), automatic control never moves the selection from backup to primary. Manual mode with the primary selected brings it back, and automatic mode enabled afterwards keeps the primary while it is present.
- R7: In manual mode (`auto_mode`=0), `use_backup` equals `sel_pin` when `sel_pin_en`=1 and `sel_reg` otherwise, one cycle after the inputs. The register is ignored while the pin is chosen, and `pri_lost` has no effect.
- R8: With no handover pending, `ref_gated` follows the level of the selected reference with a latency of SYNC_STAGES+1 clock cycles.
- R9: With the guard on (`deglitch_off`=0), a change of selection holds `ref_gated` low until the first rising edge of the newly selected reference. That edge is the first high output.
- R10: With the guard off (`deglitch_off`=1), `ref_gated` follows the new reference level at once after a change of selection, with no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_ref | input | 1 | Primary reference, raw |
| bak_ref | input | 1 | Backup reference, raw |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| hold_backup | input | 1 | 1 = stay on backup after primary returns |
| deglitch_off | input | 1 | 1 = disable the handover guard |
| sel_reg | input | 1 | Manual select bit, 1 = backup |
| sel_pin | input | 1 | Manual select pin, 1 = backup |
| sel_pin_en | input | 1 | 1 = manual choice taken from the pin |
| ref_gated | output | 1 | Gated level of the selected reference |
| use_backup | output | 1 | 1 = backup selected |
| pri_lost | output | 1 | Primary declared missing |

## Verification
The assertions check on every cycle that `pri_lost` changes state only in the cycle after a backup falling edge (when set) or a primary rising edge (when cleared). They also check that automatic moves to the backup follow a backup rising edge, that hold mode never drops the backup, that manual selection tracks its source one cycle later, and that the output stays low for as long as a handover is pending. Only the bench scenarios can show the rate-dependent outcomes. These are staying present when a primary edge falls between backup falling edges, refusing a return after three rises or an interrupted run, the first output rising edge after a handover lining up with the new reference's edge, and the exact tracking latency.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

   typedef enum logic {
      SRC_PRIMARY = 1'b0,
      SRC_BACKUP  = 1'b1
   } src_e;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } edge_t;

   localparam int NUM_REFS = 2;
   localparam int IDX_PRI  = 0;
   localparam int IDX_BAK  = 1;

endpackage

// File: rtl/refsw_sync.sv
module refsw_sync
   import refsw_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t ev
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refsw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign ev.lvl  = chain[STAGES-1];
   assign ev.rise = chain[STAGES-1] & ~last;
   assign ev.fall = ~chain[STAGES-1] & last;

endmodule

// File: rtl/refsw_monitor.sv
module refsw_monitor #(
   parameter int LOSS_EDGES   = 2,
   parameter int RETURN_EDGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_rise,
   input  logic a_fall,
   input  logic b_fall,
   output logic missing
);

   localparam int LW = $clog2(LOSS_EDGES + 1);
   localparam int RW = $clog2(RETURN_EDGES + 1);

   generate
      if (LOSS_EDGES < 1) begin : g_bad_loss
         $error("refsw_monitor: LOSS_EDGES must be at least 1");
      end
      if (RETURN_EDGES < 1) begin : g_bad_ret
         $error("refsw_monitor: RETURN_EDGES must be at least 1");
      end
   endgenerate

   logic [LW-1:0] loss_cnt;
   logic [LW-1:0] gap_cnt;
   logic [RW-1:0] ret_cnt;
   logic          missing_q;
   logic          a_edge;
   logic          armed;

   assign a_edge = a_rise | a_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loss_cnt  <= '0;
         gap_cnt   <= '0;
         ret_cnt   <= '0;
         missing_q <= 1'b0;
         armed     <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (!missing_q) begin
            gap_cnt <= '0;
            ret_cnt <= '0;
            if (a_edge) begin
               loss_cnt <= '0;
            end else if (b_fall) begin
               if (loss_cnt == LW'(LOSS_EDGES - 1)) begin
                  missing_q <= 1'b1;
                  loss_cnt  <= '0;
               end else begin
                  loss_cnt <= loss_cnt + 1'b1;
               end
            end
         end else begin
            loss_cnt <= '0;
            if (a_rise) begin
               gap_cnt <= '0;
               if (ret_cnt == RW'(RETURN_EDGES - 1)) begin
                  missing_q <= 1'b0;
                  ret_cnt   <= '0;
               end else begin
                  ret_cnt <= ret_cnt + 1'b1;
               end
            end else if (b_fall) begin
               if (gap_cnt == LW'(LOSS_EDGES - 1)) begin
                  gap_cnt <= '0;
                  ret_cnt <= '0;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign missing = missing_q;

   // R2
   loss_on_bak_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $rose(missing_q) |-> $past(b_fall));

   // R4
   return_on_pri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $fell(missing_q) |-> $past(a_rise));

endmodule

// File: rtl/refsw_select.sv
module refsw_select
   import refsw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_auto,
   input  logic cfg_stay,
   input  logic man_sel,
   input  logic missing,
   input  logic b_rise,
   output src_e nxt,
   output src_e cur
);

   src_e sel_q;
   logic armed;

   always_comb begin
      if (!cfg_auto) begin
         nxt = man_sel ? SRC_BACKUP : SRC_PRIMARY;
      end else if (missing) begin
         nxt = b_rise ? SRC_BACKUP : sel_q;
      end else if (cfg_stay) begin
         nxt = sel_q;
      end else begin
         nxt = SRC_PRIMARY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_PRIMARY;
         armed <= 1'b0;
      end else begin
         sel_q <= nxt;
         armed <= 1'b1;
      end
   end

   assign cur = sel_q;

   logic sel_bit;
   assign sel_bit = (sel_q == SRC_BACKUP);

   // R3
   auto_switch_on_bak_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cfg_auto && $past(cfg_auto) && $rose(sel_bit) |-> $past(b_rise));

   // R5
   revert_when_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cfg_auto && !cfg_stay && !missing) |-> !sel_bit);

   // R6
   hold_keeps_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cfg_auto && cfg_stay) |-> !$fell(sel_bit));

   // R7
   manual_follows_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!cfg_auto) |-> sel_bit == $past(man_sel));

endmodule

// File: rtl/refsw_gate.sv
module refsw_gate
   import refsw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic deglitch_en,
   input  src_e nxt,
   input  src_e cur,
   input  logic a_lvl,
   input  logic a_rise,
   input  logic b_lvl,
   input  logic b_rise,
   output logic gated
);

   logic new_lvl;
   logic new_rise;
   logic swap;
   logic hold_q;
   logic out_q;
   logic armed;

   assign new_lvl  = (nxt == SRC_BACKUP) ? b_lvl  : a_lvl;
   assign new_rise = (nxt == SRC_BACKUP) ? b_rise : a_rise;
   assign swap     = (nxt != cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         out_q  <= 1'b0;
         armed  <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (swap && deglitch_en) begin
            hold_q <= ~new_rise;
            out_q  <= new_rise;
         end else if (hold_q && deglitch_en) begin
            if (new_rise) begin
               hold_q <= 1'b0;
               out_q  <= 1'b1;
            end
         end else begin
            hold_q <= 1'b0;
            out_q  <= new_lvl;
         end
      end
   end

   assign gated = out_q;

   // R9
   hold_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> !out_q);

   // R9
   release_on_new_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $rose(out_q) && $past(hold_q && deglitch_en) |-> $past(new_rise));

endmodule

// File: rtl/refclk_switch.sv
module refclk_switch
   import refsw_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int LOSS_EDGES   = 2,
   parameter int RETURN_EDGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_ref,
   input  logic bak_ref,
   input  logic auto_mode,
   input  logic hold_backup,
   input  logic deglitch_off,
   input  logic sel_reg,
   input  logic sel_pin,
   input  logic sel_pin_en,
   output logic ref_gated,
   output logic use_backup,
   output logic pri_lost
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("refclk_switch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_REFS-1:0] raw;
   edge_t               ev [NUM_REFS];

   assign raw[IDX_PRI] = pri_ref;
   assign raw[IDX_BAK] = bak_ref;

   generate
      for (genvar k = 0; k < NUM_REFS; k++) begin : g_ref
         refsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[k]),
            .ev    (ev[k])
         );
      end
   endgenerate

   logic missing;
   logic man_sel;
   src_e nxt;
   src_e cur;

   assign man_sel = sel_pin_en ? sel_pin : sel_reg;

   refsw_monitor #(
      .LOSS_EDGES   (LOSS_EDGES),
      .RETURN_EDGES (RETURN_EDGES)
   ) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_rise  (ev[IDX_PRI].rise),
      .a_fall  (ev[IDX_PRI].fall),
      .b_fall  (ev[IDX_BAK].fall),
      .missing (missing)
   );

   refsw_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_auto (auto_mode),
      .cfg_stay (hold_backup),
      .man_sel  (man_sel),
      .missing  (missing),
      .b_rise   (ev[IDX_BAK].rise),
      .nxt      (nxt),
      .cur      (cur)
   );

   refsw_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .deglitch_en (~deglitch_off),
      .nxt         (nxt),
      .cur         (cur),
      .a_lvl       (ev[IDX_PRI].lvl),
      .a_rise      (ev[IDX_PRI].rise),
      .b_lvl       (ev[IDX_BAK].lvl),
      .b_rise      (ev[IDX_BAK].rise),
      .gated       (ref_gated)
   );

   assign use_backup = (cur == SRC_BACKUP);
   assign pri_lost   = missing;

endmodule

// File: tb/tb_refclk_switch.sv
module tb_refclk_switch;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_a = 1'b0;
   logic ref_b = 1'b0;
   logic auto_mode = 1'b1;
   logic hold_backup = 1'b0;
   logic deglitch_off = 1'b0;
   logic sel_reg = 1'b0;
   logic sel_pin = 1'b0;
   logic sel_pin_en = 1'b0;
   logic ref_gated;
   logic use_backup;
   logic pri_lost;

   int checks = 0;
   int errors = 0;
   int a_half = 3;
   int b_half = 4;
   int a_cnt = 0;
   int b_cnt = 0;
   int a_burst = -1;
   bit a_run = 1'b1;
   bit b_run = 1'b1;
   bit b_park = 1'b0;
   bit ha[4];
   bit hb[4];
   bit trk_on = 1'b0;
   bit trk_b = 1'b0;
   int trk_err = 0;
   bit hi_on = 1'b0;
   int hi_cnt = 0;
   bit fw_on = 1'b0;
   bit fw_done = 1'b0;
   bit fw_ok = 1'b0;
   bit done = 1'b0;

   refclk_switch dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pri_ref      (ref_a),
      .bak_ref      (ref_b),
      .auto_mode    (auto_mode),
      .hold_backup  (hold_backup),
      .deglitch_off (deglitch_off),
      .sel_reg      (sel_reg),
      .sel_pin      (sel_pin),
      .sel_pin_en   (sel_pin_en),
      .ref_gated    (ref_gated),
      .use_backup   (use_backup),
      .pri_lost     (pri_lost)
   );

   initial forever #4 clk = ~clk;

   // Reference generators, output observers and input history, all at the falling edge.
   initial forever begin
      @(negedge clk);
      if (trk_on && (ref_gated !== (trk_b ? hb[2] : ha[2]))) trk_err++;
      if (hi_on && ref_gated) hi_cnt++;
      if (fw_on && !fw_done && ref_gated) begin
         fw_done = 1'b1;
         fw_ok   = hb[2] && !hb[3];
      end
      if ((a_run && a_burst != 0) || ref_a) begin
         a_cnt++;
         if (a_cnt >= a_half) begin
            a_cnt = 0;
            ref_a = ~ref_a;
            if (ref_a && a_burst > 0) a_burst--;
         end
      end
      if (b_run || (ref_b != b_park)) begin
         b_cnt++;
         if (b_cnt >= b_half) begin
            b_cnt = 0;
            ref_b = ~ref_b;
         end
      end
      for (int i = 3; i > 0; i--) begin
         ha[i] = ha[i-1];
         hb[i] = hb[i-1];
      end
      ha[0] = ref_a;
      hb[0] = ref_b;
   end

   function automatic bit exp_manual(input bit pin_en, input bit pin, input bit rg);
      return pin_en ? pin : rg;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic track(input bit use_b, input int n, input string req);
      trk_b   = use_b;
      trk_err = 0;
      trk_on  = 1'b1;
      cyc(n);
      trk_on  = 1'b0;
      chk(trk_err == 0, req, trk_err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit e;
      bit lose;
      void'($urandom(32'h00C0FFEE));
      cyc(6);
      // R1: outputs idle during reset
      chk(ref_gated == 0 && use_backup == 0 && pri_lost == 0, "R1 reset state",
          {ref_gated, use_backup, pri_lost}, 0);
      rst_n = 1'b1;
      cyc(1);
      chk(use_backup == 0 && pri_lost == 0, "R1 after release", {use_backup, pri_lost}, 0);

      // R8: both running, automatic revert mode, tracks primary
      cyc(40);
      chk(pri_lost == 0, "R2 present primary not lost", pri_lost, 0);
      track(1'b0, 80, "R8 primary tracking");

      // R2: primary edge every 7 cycles, backup falls every 8: never lost
      a_half = 7;
      cyc(150);
      chk(pri_lost == 0, "R2 one backup fall between primary edges", pri_lost, 0);
      a_half = 3;
      cyc(20);

      // R2/R3: stop primary
      a_run = 1'b0;
      cyc(60);
      chk(pri_lost == 1, "R2 loss after two backup falls", pri_lost, 1);
      chk(use_backup == 1, "R3 automatic switch to backup", use_backup, 1);
      track(1'b1, 40, "R3 backup tracking after loss");

      // R4: short and interrupted returns
      a_run = 1'b1;
      a_burst = 3;
      cyc(80);
      chk(pri_lost == 1, "R4 three rises not enough", pri_lost, 1);
      a_burst = 2;
      cyc(30);
      a_burst = 2;
      cyc(60);
      chk(pri_lost == 1, "R4 interrupted run not enough", pri_lost, 1);
      chk(use_backup == 1, "R4 stays on backup while lost", use_backup, 1);

      // R4/R5: full return, revert
      a_burst = -1;
      cyc(80);
      chk(pri_lost == 0, "R4 return after four rises", pri_lost, 0);
      chk(use_backup == 0, "R5 revert to primary", use_backup, 0);
      track(1'b0, 40, "R5 primary tracking after revert");

      // R6: hold mode
      hold_backup = 1'b1;
      a_burst = 0;
      cyc(80);
      chk(use_backup == 1, "R6 hold mode loss switches", use_backup, 1);
      a_burst = -1;
      cyc(100);
      chk(pri_lost == 0, "R6 primary back", pri_lost, 0);
      chk(use_backup == 1, "R6 stays on backup", use_backup, 1);
      auto_mode = 1'b0;
      sel_pin_en = 1'b0;
      sel_reg = 1'b0;
      cyc(40);
      chk(use_backup == 0, "R6 manual brings primary back", use_backup, 0);
      auto_mode = 1'b1;
      cyc(60);
      chk(use_backup == 0, "R6 automatic re-enabled keeps primary", use_backup, 0);

      // R7: pin precedence and loss ignored in manual mode
      auto_mode = 1'b0;
      sel_pin_en = 1'b1;
      sel_pin = 1'b1;
      sel_reg = 1'b0;
      cyc(30);
      chk(use_backup == 1, "R7 pin selects backup", use_backup, 1);
      sel_pin = 1'b0;
      sel_reg = 1'b1;
      cyc(30);
      chk(use_backup == 0, "R7 register ignored while pin chosen", use_backup, 0);
      a_burst = 0;
      cyc(60);
      chk(pri_lost == 1, "R2 monitor active in manual mode", pri_lost, 1);
      chk(use_backup == 0, "R7 loss has no effect in manual mode", use_backup, 0);
      a_burst = -1;
      cyc(80);

      // R9: guard on, switch to a backup parked high
      sel_pin_en = 1'b0;
      sel_reg = 1'b0;
      deglitch_off = 1'b0;
      b_run = 1'b0;
      b_park = 1'b1;
      cyc(20);
      sel_reg = 1'b1;
      hi_cnt = 0;
      hi_on = 1'b1;
      cyc(30);
      hi_on = 1'b0;
      chk(hi_cnt == 0, "R9 held low while no new rising edge", hi_cnt, 0);
      chk(use_backup == 1, "R7 register selects backup", use_backup, 1);
      fw_done = 1'b0;
      fw_on = 1'b1;
      b_run = 1'b1;
      cyc(40);
      fw_on = 1'b0;
      chk(fw_done && fw_ok, "R9 first high at new rising edge", {fw_done, fw_ok}, 3);
      track(1'b1, 40, "R9 tracking after release");

      // R10: guard off, output follows parked-high backup at once
      sel_reg = 1'b0;
      cyc(40);
      b_run = 1'b0;
      b_park = 1'b1;
      cyc(20);
      deglitch_off = 1'b1;
      sel_reg = 1'b1;
      cyc(6);
      chk(ref_gated == 1, "R10 no hold with guard off", ref_gated, 1);
      b_run = 1'b1;
      b_park = 1'b0;
      deglitch_off = 1'b0;
      cyc(20);

      // R7/R8: random manual selections
      for (int it = 0; it < 40; it++) begin
         a_half = 2 + int'($urandom_range(5));
         b_half = 2 + int'($urandom_range(5));
         sel_pin_en = 1'($urandom_range(1));
         sel_pin = 1'($urandom_range(1));
         sel_reg = 1'($urandom_range(1));
         deglitch_off = 1'($urandom_range(1));
         a_run = ($urandom_range(3) != 0);
         cyc(60);
         e = exp_manual(sel_pin_en, sel_pin, sel_reg);
         chk(use_backup == e, "R7 random manual select", use_backup, e);
         track(e, 40, "R8 random tracking");
      end

      // R2/R5: random automatic revert runs
      auto_mode = 1'b1;
      hold_backup = 1'b0;
      deglitch_off = 1'b0;
      for (int it = 0; it < 20; it++) begin
         b_half = 3 + int'($urandom_range(4));
         a_half = 2 + int'($urandom_range(b_half - 2));
         lose = ($urandom_range(2) == 0);
         a_run = !lose;
         cyc(160);
         chk(pri_lost == lose, "R2 random loss state", pri_lost, lose);
         chk(use_backup == lose, "R5 random automatic selection", use_backup, lose);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule